// File: doc/BRIEF.md
# Sign-Magnitude Adder-Subtractor

This block takes two N-bit integers in sign-magnitude form and produces their sum or difference, also in sign-magnitude form. The top bit of each word is the sign: 0 for positive and 1 for negative. The other N-1 bits hold the unsigned magnitude.

To subtract, the block inverts the sign of the second operand and then runs the same add path.

- **Equal effective signs:** the magnitudes are added. The result keeps the common sign. A carry out of the magnitude field raises overflow.
- **Different effective signs:** the magnitudes are compared and the smaller is taken from the larger. The result gets the sign of the operand with the larger magnitude.
- **Zero results:** a zero magnitude always leaves with a positive sign, so negative zero never appears at the output.

The result, the overflow flag and a 2N-bit widened copy of the result are captured in registers. The widened copy puts the sign at the new top bit and fills the new magnitude bits with zeros.

A two-state machine drives the result-valid strobe:
- **ST_IDLE:** no fresh result. The block moves to ST_EMIT (transition LOAD) on a clock edge where `in_valid` is high.
- **ST_EMIT:** a fresh result is held for one cycle. The block returns to ST_IDLE (transition DRAIN) when `in_valid` is low, or stays in ST_EMIT (transition RELOAD) when it is high.
- **Reset:** forces ST_IDLE.

Top module: `sm_addsub`

## Requirements
- R1: Operands and result use sign-magnitude encoding: bit N-1 is the sign (0 positive, 1 negative) and bits N-2..0 are the unsigned magnitude.
- R2: When the effective signs are equal, the result magnitude is the sum of the operand magnitudes and the result sign is the common sign.
- R3: When the effective signs are equal and the magnitude sum exceeds 2^(N-1)-1, `ovf_out` is 1 and the result magnitude is the sum modulo 2^(N-1). In every other case `ovf_out` is 0.
- R4: When the effective signs differ, the result magnitude is the larger magnitude minus the smaller, and the result sign is the sign of the operand with the larger magnitude.
- R5: When the effective signs differ and the magnitudes are equal, the result is +0 (all bits zero).
- R6: With `op_sub`=1, the result equals A plus B with B's sign bit inverted. With `op_sub`=0, the result is A plus B.
- R7: The result never has sign 1 with magnitude 0; any zero result, including one built from -0 operands, is output as +0.
- R8: The registered outputs update on the clock edge where `in_valid` is 1, and `out_valid` is 1 for exactly the following cycle.
- R9: On an edge where `in_valid` is 0, `sum_out`, `ovf_out` and `wide_out` keep their values.
- R10: `wide_out` equals the result widened to 2N bits: bit 2N-1 is the result sign, bits 2N-2..N-1 are zero, and bits N-2..0 are the result magnitude.
- R11: A synchronous active-high `rst` clears `sum_out`, `ovf_out`, `wide_out` and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| op_sub | input | 1 | 1 selects A - B, 0 selects A + B |
| opnd_a | input | N | Operand A, sign-magnitude |
| opnd_b | input | N | Operand B, sign-magnitude |
| sum_out | output | N | Registered result, sign-magnitude |
| ovf_out | output | 1 | Registered overflow flag |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| wide_out | output | 2N | Registered result widened to 2N bits |

## Verification
Same-sign pairs, both positive and both negative, tell the magnitude-add path apart from the compare-and-subtract path. Sums just below and just above the magnitude limit show that overflow is raised exactly on a carry out.

Mixed-sign pairs are run with the larger magnitude on each side in turn, which checks that the result sign follows the larger operand rather than operand A. Equal-magnitude pairs and -0 operands show that zero is always folded to +0.

Each pattern is repeated with subtraction selected, which checks the sign inversion of B. Idle cycles between operations separate loading from holding and confirm the single-cycle valid pulse.

// File: rtl/sm_pkg.sv
package sm_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_t;
endpackage

// File: rtl/sm_mag_cmp.sv
module sm_mag_cmp #(
    parameter int W = 7
) (
    input  logic [W-1:0] mag_x,
    input  logic [W-1:0] mag_y,
    output logic         x_ge_y
);
    always_comb begin
        x_ge_y = (mag_x >= mag_y);
    end
endmodule

// File: rtl/sm_mag_unit.sv
module sm_mag_unit #(
    parameter int W = 7
) (
    input  logic [W-1:0] big_mag,
    input  logic [W-1:0] small_mag,
    input  logic         subtract,
    output logic [W-1:0] res_mag,
    output logic         carry
);
    logic [W:0] wide_sum;

    always_comb begin
        if (subtract) begin
            wide_sum = {1'b0, big_mag} - {1'b0, small_mag};
        end else begin
            wide_sum = {1'b0, big_mag} + {1'b0, small_mag};
        end
        res_mag = wide_sum[W-1:0];
        carry   = subtract ? 1'b0 : wide_sum[W];
    end
endmodule

// File: rtl/sm_widen.sv
module sm_widen #(
    parameter int NI = 8,
    parameter int NO = 16
) (
    input  logic [NI-1:0] narrow,
    output logic [NO-1:0] wide
);
    localparam int FILL = NO - NI;

    generate
        if (FILL > 0) begin : g_pad
            assign wide = {narrow[NI-1], {FILL{1'b0}}, narrow[NI-2:0]};
        end else begin : g_same
            assign wide = narrow[NO-1:0];
        end
    endgenerate
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           op_sub,
    input  logic [N-1:0]   opnd_a,
    input  logic [N-1:0]   opnd_b,
    output logic [N-1:0]   sum_out,
    output logic           ovf_out,
    output logic           out_valid,
    output logic [2*N-1:0] wide_out
);
    import sm_pkg::*;

    localparam int MW = N - 1;
    localparam int WW = 2 * N;

    emit_state_t state_q, state_d;

    logic          a_sgn, b_sgn_eff, signs_diff, a_ge_b;
    logic [MW-1:0] a_mag, b_mag, big_mag, small_mag, res_mag;
    logic          carry, raw_sign, res_sign, ovf_d;
    logic [N-1:0]  res_d;
    logic [WW-1:0] wide_d;

    // Operand split; subtraction flips B's sign only.
    always_comb begin
        a_sgn      = opnd_a[N-1];
        a_mag      = opnd_a[MW-1:0];
        b_sgn_eff  = opnd_b[N-1] ^ op_sub;
        b_mag      = opnd_b[MW-1:0];
        signs_diff = a_sgn ^ b_sgn_eff;
    end

    sm_mag_cmp #(.W(MW)) u_cmp (
        .mag_x  (a_mag),
        .mag_y  (b_mag),
        .x_ge_y (a_ge_b)
    );

    always_comb begin
        big_mag   = a_ge_b ? a_mag : b_mag;
        small_mag = a_ge_b ? b_mag : a_mag;
    end

    sm_mag_unit #(.W(MW)) u_unit (
        .big_mag   (big_mag),
        .small_mag (small_mag),
        .subtract  (signs_diff),
        .res_mag   (res_mag),
        .carry     (carry)
    );

    // Sign of larger operand; zero magnitude folds to +0.
    always_comb begin
        if (signs_diff) begin
            raw_sign = a_ge_b ? a_sgn : b_sgn_eff;
        end else begin
            raw_sign = a_sgn;
        end
        res_sign = raw_sign & (|res_mag);
        res_d    = {res_sign, res_mag};
        ovf_d    = ~signs_diff & carry;
    end

    sm_widen #(.NI(N), .NO(WW)) u_widen (
        .narrow (res_d),
        .wide   (wide_d)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;   // LOAD
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;   // RELOAD / DRAIN
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            sum_out  <= '0;
            ovf_out  <= 1'b0;
            wide_out <= '0;
        end else if (in_valid) begin
            sum_out  <= res_d;
            ovf_out  <= ovf_d;
            wide_out <= wide_d;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/sm_addsub_chk.sv
module sm_addsub_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic           op_sub,
    input logic [N-1:0]   opnd_a,
    input logic [N-1:0]   opnd_b,
    input logic [N-1:0]   sum_out,
    input logic           ovf_out,
    input logic           out_valid,
    input logic [2*N-1:0] wide_out
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                          // R8
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                        // R8
    AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (sum_out != {1'b1, {(N-1){1'b0}}}));                // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(sum_out) && $stable(ovf_out) && $stable(wide_out))); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (opnd_a[N-1] != (opnd_b[N-1] ^ op_sub))) |=> !ovf_out); // R3
    AST_WIDE_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (wide_out == {sum_out[N-1], {N{1'b0}}, sum_out[N-2:0]})); // R10
endmodule

bind sm_addsub sm_addsub_chk #(.N(N)) u_sm_addsub_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_sub    (op_sub),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .sum_out   (sum_out),
    .ovf_out   (ovf_out),
    .out_valid (out_valid),
    .wide_out  (wide_out)
);

// File: tb/test_sm_addsub.sv
`timescale 1ns/1ps
module test_sm_addsub;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic           in_valid;
    logic           op_sub;
    logic [N-1:0]   opnd_a;
    logic [N-1:0]   opnd_b;
    logic [N-1:0]   sum_out;
    logic           ovf_out;
    logic           out_valid;
    logic [2*N-1:0] wide_out;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    sm_addsub #(.N(N)) i_sm_addsub (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sum_out(sum_out),
        .ovf_out(ovf_out), .out_valid(out_valid), .wide_out(wide_out)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Reference from integer arithmetic (R1..R7).
    function automatic void model(input logic [N-1:0] a, input logic [N-1:0] b, input bit s,
                                  output logic [N-1:0] r, output bit ov);
        int va, vb, vr, m;
        va = a[N-1] ? -int'(a[N-2:0]) : int'(a[N-2:0]);
        vb = b[N-1] ? -int'(b[N-2:0]) : int'(b[N-2:0]);
        vr = s ? va - vb : va + vb;
        m  = (vr < 0) ? -vr : vr;
        ov = (m > (1 << (N-1)) - 1);
        m  = m % (1 << (N-1));
        r  = {((vr < 0) && (m != 0)), m[N-2:0]};
    endfunction

    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input bit s, input string tag);
        logic [N-1:0] er;
        bit eo;
        model(a, b, s, er, eo);
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sub = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(sum_out == er, tag, sum_out, er);
        chk(ovf_out == eo, {tag, " R3 ovf"}, ovf_out, eo);
        chk(out_valid == 1'b1, "R8 valid", out_valid, 1);
        chk(wide_out == {er[N-1], {N{1'b0}}, er[N-2:0]}, "R10 wide", wide_out,
            {er[N-1], {N{1'b0}}, er[N-2:0]});
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; op_sub = 1'b0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(negedge clk);
        chk(sum_out == 0 && ovf_out == 0 && wide_out == 0, "R11 outputs", sum_out, 0);
        chk(out_valid == 0, "R11 valid", out_valid, 0);
        rst = 1'b0;
    endtask

    task automatic t_same_sign;   // R1 R2
        run_op(8'h12, 8'h05, 1'b0, "R2 +18+5");
        run_op(8'h92, 8'h85, 1'b0, "R2 -18-5");
        run_op(8'h00, 8'h33, 1'b0, "R1 0+51");
    endtask

    task automatic t_overflow;    // R3
        run_op(8'h40, 8'h3F, 1'b0, "R3 127 edge");
        run_op(8'h40, 8'h40, 1'b0, "R3 +64+64");
        run_op(8'hFF, 8'h82, 1'b0, "R3 -127-2");
        run_op(8'h7F, 8'h01, 1'b0, "R3 127+1");
    endtask

    task automatic t_diff_sign;   // R4
        run_op(8'h3C, 8'h85, 1'b0, "R4 60-5");
        run_op(8'h05, 8'hBC, 1'b0, "R4 5-60");
        run_op(8'h85, 8'h3C, 1'b0, "R4 -5+60");
        run_op(8'hBC, 8'h05, 1'b0, "R4 -60+5");
    endtask

    task automatic t_cancel;      // R5
        run_op(8'h22, 8'hA2, 1'b0, "R5 +34-34");
        run_op(8'hA2, 8'h22, 1'b0, "R5 -34+34");
        run_op(8'h22, 8'h22, 1'b1, "R5 34-34");
    endtask

    task automatic t_sub;         // R6
        run_op(8'h05, 8'h02, 1'b1, "R6 5-2");
        run_op(8'h05, 8'h82, 1'b1, "R6 5-(-2)");
        run_op(8'h86, 8'h04, 1'b1, "R6 -6-4");
        run_op(8'h02, 8'h07, 1'b1, "R6 2-7");
        run_op(8'h7F, 8'hFF, 1'b1, "R6 127-(-127)");
    endtask

    task automatic t_neg_zero;    // R7
        run_op(8'h80, 8'h80, 1'b0, "R7 -0+-0");
        run_op(8'h80, 8'h00, 1'b1, "R7 -0-0");
        run_op(8'hC0, 8'hC0, 1'b0, "R7 ovf to zero");
    endtask

    task automatic t_hold;        // R8 R9
        logic [N-1:0] held;
        run_op(8'h91, 8'h02, 1'b0, "R9 load");
        held = sum_out;
        @(negedge clk);
        opnd_a = 8'h7F; opnd_b = 8'h7F; op_sub = 1'b0;
        chk(out_valid == 0, "R8 pulse ends", out_valid, 0);
        @(negedge clk);
        chk(sum_out == held, "R9 hold", sum_out, held);
        chk(ovf_out == 0, "R9 hold ovf", ovf_out, 0);
    endtask

    task automatic t_widen;       // R10
        run_op(8'h92, 8'h00, 1'b0, "R10 -18");
        chk(wide_out == 16'h8012, "R10 -18 wide", wide_out, 16'h8012);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_same_sign();
        t_overflow();
        t_diff_sign();
        t_cancel();
        t_sub();
        t_neg_zero();
        t_hold();
        t_widen();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule